// File: doc/BRIEF.md
# Dual-Rail Handshake Register Stage

This block is one pipeline register of a delay-insensitive datapath. Every data bit travels on a pair of rails, a true rail and a false rail. Each rail is stored in a two-input C-element. One input of that C-element is the incoming rail. The other is an enable taken as the inverse of the downstream acknowledge. A new wavefront therefore moves to the outputs only after the receiver has acknowledged the previous one.

A completion detector watches the stored rails and produces the acknowledge sent back to the upstream sender. The parameter `RTO` selects the signalling scheme. With `RTO=0` the spacer is all zeros (return-to-zero). With `RTO=1` the spacer is all ones (return-to-one). Both schemes use the same storage structure. Only the per-bit completion gate and the reset values change.

The C-elements are modelled as state elements sampled on `clk`. Each one takes a new value only at a clock edge, and only when both of its inputs agree.

Top module: `dr_hs_stage`

## Requirements
- R1: With `RTO=0`, logic 1 is carried as (true,false)=(1,0), logic 0 as (0,1), and the spacer is (0,0). A data word presented while `ack_rx`=0 appears unchanged on `out_t`/`out_f` one clock later.
- R2: With `RTO=1`, logic 1 is carried as (true,false)=(0,1), logic 0 as (1,0), and the spacer is (1,1). A data word presented while `ack_rx`=1 appears unchanged on the outputs one clock later.
- R3: When all input rail pairs are legal codes, no output rail pair ever shows the illegal code: (1,1) for `RTO=0`, (0,0) for `RTO=1`.
- R4: Each output rail is a C-element of its input rail and `~ack_rx`. At a clock edge it takes value v only if both of those equal v. Otherwise it keeps its value.
- R5: Under a sender and a receiver that follow the 4-phase order with random delays, every data word reaches the outputs complete, intact and in the order it was sent. This holds for both signalling schemes.
- R6: `ack_tx` goes to 1 one clock after the outputs hold a complete data word (`RTO=0`) or the all-ones spacer (`RTO=1`). It goes to 0 one clock after the outputs hold the all-zeros spacer (`RTO=0`) or a complete data word (`RTO=1`). It holds in every other case.
- R7: While `rst_n`=0, every output rail is at the spacer level of the selected scheme, and `ack_tx` equals `RTO`.
- R8: If the inputs return to spacer before `ack_rx` has changed, the stored data word stays on the outputs. It is replaced by the spacer one clock after `ack_rx` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the C-element state |
| rst_n | input | 1 | Active-low reset, forces spacer |
| in_t | input | WIDTH | Incoming true rails |
| in_f | input | WIDTH | Incoming false rails |
| ack_rx | input | 1 | Acknowledge from the downstream receiver |
| out_t | output | WIDTH | Stored true rails |
| out_f | output | WIDTH | Stored false rails |
| ack_tx | output | 1 | Completion acknowledge to the upstream sender |

## Verification
The assertions assume that the sender never places an illegal rail pair on the inputs. They also assume that rails change monotonically within a phase: rising only towards data under return-to-zero, falling only towards data under return-to-one. The modelled sender keeps to both. It changes one rail pair at a time, always to a legal code. It moves to the next phase only after `ack_tx` has reached the required level. The modelled receiver changes `ack_rx` only after the outputs hold a complete word or a complete spacer. The one deliberate break in the phase order, returning the inputs to spacer before the acknowledge moves, still keeps every input code legal.

// File: rtl/dr_hs_stage.sv
module dr_hs_stage #(
  parameter int WIDTH = 8,
  parameter bit RTO   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] in_t,
  input  logic [WIDTH-1:0] in_f,
  input  logic             ack_rx,
  output logic [WIDTH-1:0] out_t,
  output logic [WIDTH-1:0] out_f,
  output logic             ack_tx
);
  localparam logic SPC = RTO;

  logic             en;
  logic [WIDTH-1:0] done;

  assign en   = ~ack_rx;
  assign done = RTO ? (out_t & out_f) : (out_t | out_f);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               out_t[i] <= SPC;
      else if (in_t[i] == en)   out_t[i] <= en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               out_f[i] <= SPC;
      else if (in_f[i] == en)   out_f[i] <= en;
    end

    // R3
    p_no_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      RTO ? (out_t[i] | out_f[i]) : !(out_t[i] & out_f[i]));

    // R4: a change needs agreement of rail and enable in the prior cycle
    p_true_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_t[i] != $past(out_t[i])) |->
        (out_t[i] == $past(in_t[i]) && out_t[i] == $past(~ack_rx)));
    p_false_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_f[i] != $past(out_f[i])) |->
        (out_f[i] == $past(in_f[i]) && out_f[i] == $past(~ack_rx)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ack_tx <= RTO;
    else if (&done)    ack_tx <= 1'b1;
    else if (~|done)   ack_tx <= 1'b0;
  end

  // R6
  p_ack_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_tx) |-> $past(RTO ? (&out_t && &out_f) : &(out_t ^ out_f)));
  p_ack_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_tx) |-> $past(RTO ? &(out_t ^ out_f) : (~|out_t && ~|out_f)));
endmodule

// File: tb/tb_dr_hs_stage.sv
module tb_agent #(
  parameter int WIDTH = 8,
  parameter bit RTO   = 1'b0,
  parameter int NWORD = 200
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   fails,
  output logic done
);
  logic [WIDTH-1:0] in_t, in_f, out_t, out_f;
  logic             ack_rx, ack_tx;
  logic [WIDTH-1:0] sent_q[$];
  int               got, illegal;
  logic [WIDTH-1:0] spc_w;

  dr_hs_stage #(.WIDTH(WIDTH), .RTO(RTO)) dut (
    .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .ack_rx(ack_rx),
    .out_t(out_t), .out_f(out_f), .ack_tx(ack_tx));

  assign spc_w = RTO ? '1 : '0;

  function automatic logic [WIDTH-1:0] enc_t(input logic [WIDTH-1:0] d);
    return RTO ? ~d : d;
  endfunction
  function automatic logic [WIDTH-1:0] enc_f(input logic [WIDTH-1:0] d);
    return RTO ? d : ~d;
  endfunction
  function automatic logic [WIDTH-1:0] dec(input logic [WIDTH-1:0] t, input logic [WIDTH-1:0] f);
    return RTO ? f : t;
  endfunction
  function automatic bit is_data(input logic [WIDTH-1:0] t, input logic [WIDTH-1:0] f);
    return &(t ^ f);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (RTO=%0d): actual %h expected %h", req, RTO, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  always @(negedge clk)
    if (rst_n)
      for (int i = 0; i < WIDTH; i++)
        if (RTO ? !(out_t[i] | out_f[i]) : (out_t[i] & out_f[i])) illegal++;

  task automatic sender();
    for (int n = 0; n < NWORD; n++) begin
      logic [WIDTH-1:0] w;
      w = (n == 0) ? '0 : (n == 1) ? '1 : WIDTH'($urandom);
      while (ack_tx != RTO) @(negedge clk);
      wait_cyc($urandom_range(0, 3));
      sent_q.push_back(w);
      for (int i = 0; i < WIDTH; i++) begin
        in_t[i] = enc_t(w)[i];
        in_f[i] = enc_f(w)[i];
        wait_cyc($urandom_range(0, 1));
      end
      while (ack_tx == RTO) @(negedge clk);
      wait_cyc($urandom_range(0, 3));
      for (int i = 0; i < WIDTH; i++) begin
        in_t[i] = RTO;
        in_f[i] = RTO;
        wait_cyc($urandom_range(0, 1));
      end
    end
  endtask

  task automatic receiver();
    while (got < NWORD) begin
      logic [WIDTH-1:0] exp_w;
      @(negedge clk);
      if (is_data(out_t, out_f)) begin
        wait_cyc($urandom_range(0, 3));
        exp_w = sent_q.pop_front();
        chk(dec(out_t, out_f) == exp_w, "R5 word order/value", 64'(dec(out_t, out_f)), 64'(exp_w));
        got++;
        ack_rx = !RTO;
        while (!(out_t == spc_w && out_f == spc_w)) @(negedge clk);
        wait_cyc($urandom_range(0, 3));
        ack_rx = RTO;
      end
    end
  endtask

  initial begin
    logic [WIDTH-1:0] d;
    checks = 0; fails = 0; done = 1'b0; got = 0; illegal = 0;
    void'($urandom(32'd41 + 32'(RTO)));
    in_t = spc_w; in_f = spc_w; ack_rx = RTO;
    @(negedge clk);
    chk(out_t == spc_w && out_f == spc_w, "R7 reset rails", 64'({out_t, out_f}), 64'({spc_w, spc_w}));
    chk(ack_tx == RTO, "R7 reset ack_tx", 64'(ack_tx), 64'(RTO));
    @(posedge rst_n);
    @(negedge clk);
    d = WIDTH'(32'hA5C3);
    in_t = enc_t(d); in_f = enc_f(d);
    @(negedge clk);
    chk(out_t == enc_t(d) && out_f == enc_f(d), RTO ? "R2 data encoding" : "R1 data encoding",
        64'({out_t, out_f}), 64'({enc_t(d), enc_f(d)}));
    chk(ack_tx == RTO, "R6 ack waits a cycle", 64'(ack_tx), 64'(RTO));
    @(negedge clk);
    chk(ack_tx == !RTO, "R6 ack after complete data", 64'(ack_tx), 64'(!RTO));
    in_t = spc_w; in_f = spc_w;
    wait_cyc(3);
    chk(out_t == enc_t(d) && out_f == enc_f(d), "R8 hold until ack", 64'({out_t, out_f}), 64'({enc_t(d), enc_f(d)}));
    chk(ack_tx == !RTO, "R6 ack holds", 64'(ack_tx), 64'(!RTO));
    ack_rx = !RTO;
    @(negedge clk);
    chk(out_t == spc_w && out_f == spc_w, "R8 spacer after ack", 64'({out_t, out_f}), 64'({spc_w, spc_w}));
    @(negedge clk);
    chk(ack_tx == RTO, "R6 ack after spacer", 64'(ack_tx), 64'(RTO));
    d = WIDTH'(32'h3C);
    in_t = enc_t(d); in_f = enc_f(d);
    wait_cyc(2);
    chk(out_t == spc_w && out_f == spc_w, "R4 blocked while enable opposes", 64'({out_t, out_f}), 64'({spc_w, spc_w}));
    in_t = spc_w; in_f = spc_w;
    ack_rx = RTO;
    wait_cyc(2);
    chk(out_t == spc_w && ack_tx == RTO, "R4 idle spacer", 64'({out_t, ack_tx}), 64'({spc_w, RTO}));
    fork
      sender();
      receiver();
    join
    chk(got == NWORD, "R5 word count", 64'(got), 64'(NWORD));
    chk(illegal == 0, "R3 illegal output codes", 64'(illegal), 64'd0);
    done = 1'b1;
  end
endmodule

module tb_dr_hs_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c0, f0, c1, f1;
  logic d0, d1;
  int   wd_fail;

  always #5 clk = ~clk;

  tb_agent #(.RTO(1'b0)) dut_rtz (.clk(clk), .rst_n(rst_n), .checks(c0), .fails(f0), .done(d0));
  tb_agent #(.RTO(1'b1)) dut_rto (.clk(clk), .rst_n(rst_n), .checks(c1), .fails(f1), .done(d1));

  initial begin
    wd_fail = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 150000 && !(d0 && d1); k++) @(negedge clk);
    if (!(d0 && d1)) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual not done expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", c0 + c1 + wd_fail, f0 + f1 + wd_fail);
    $finish;
  end
endmodule